// File: doc/BRIEF.md
# Dual-Channel Threshold Interrupt Controller

This block turns per-measurement window results from two sensing channels, ambient light and proximity, into one active-low interrupt line. Each channel delivers a strobe together with an indication that the latest result fell outside its threshold window. A persistence filter per channel counts consecutive out-of-window results. The channel's flag is raised only when the count reaches a programmed length. Once raised, a flag holds until software clears it.

The two flags are merged by a selectable OR or AND. The merged level, registered once, drives an open-drain output, modelled as an output enable with a constant-low data value. A single byte-wide register holds the two flags, the two persistence codes and the merge select. Software reads it in full. A write updates the configuration fields and clears any flag whose bit is written as 0.

Top module: `dual_thresh_irq`

## Requirements
- R1: After reset the register reads 0x00, both flags are clear and `irq_oe` is 0.
- R2: Register layout: bit 0 merge select, bits 2:1 ambient persistence code, bit 3 ambient flag, bit 4 always reads 0, bits 6:5 proximity persistence code, bit 7 proximity flag. A write stores bits 6:5, 2:1 and 0, and they read back from the next cycle.
- R3: Persistence code 00, 01, 10, 11 requires 1, 4, 8, 16 consecutive out-of-window strobes. The flag is set at the clock edge that registers the strobe completing the run. The code in force before a same-cycle write applies.
- R4: A strobe with an in-window result restarts that channel's run from zero. Cycles without a strobe neither extend nor restart the run.
- R5: A set flag stays set while later strobes report in-window results, until software clears it.
- R6: A write with a flag bit (7 or 3) at 0 clears that flag and restarts that channel's run. The clear wins over a strobe in the same cycle.
- R7: Writing 1 to a flag bit leaves the flag unchanged and never sets it.
- R8: With merge select 0 the interrupt is asserted when either flag is set. With merge select 1 it is asserted only when both are set.
- R9: `irq_oe` reflects the flags and merge select one clock edge after they change. `irq_od` is always 0, so the pin pulls low exactly when `irq_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| amb_valid | input | 1 | Ambient measurement strobe |
| amb_outside | input | 1 | Ambient result lies outside its window |
| prx_valid | input | 1 | Proximity measurement strobe |
| prx_outside | input | 1 | Proximity result lies outside its window |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_oe | output | 1 | Open-drain output enable (1 pulls the line low) |
| irq_od | output | 1 | Open-drain data value, constant 0 |

## Verification
The assertions assume that `*_outside` is meaningful only in a cycle where its strobe is high. They also assume that the register write strobe may coincide with a measurement strobe on either channel, which is why clear priority is checked. The bench keeps the outside indications low whenever no strobe is given. It deliberately places writes, both clear and non-clear, in the same cycles as out-of-window strobes to exercise that priority.

// File: rtl/dti_pkg.sv
package dti_pkg;

    localparam int PERSIST_MAX = 16;
    localparam int CNT_W       = $clog2(PERSIST_MAX + 1);
    localparam int NUM_CH      = 2;
    localparam int CH_AMB      = 0;
    localparam int CH_PRX      = 1;

    localparam int BIT_SEL      = 0;
    localparam int BIT_AMB_CODE = 1;
    localparam int BIT_AMB_FLAG = 3;
    localparam int BIT_PRX_CODE = 5;
    localparam int BIT_PRX_FLAG = 7;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [1:0]       code_t;

    typedef struct packed {
        code_t prx_code;
        code_t amb_code;
        logic  sel_and;
    } cfg_t;

    function automatic cnt_t persist_need(input code_t code);
        cnt_t n;
        if (code == 2'd0) n = cnt_t'(1);
        else              n = cnt_t'(2 << code);
        return n;
    endfunction

endpackage

// File: rtl/dti_persist.sv
module dti_persist
    import dti_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  code_t code,
    input  logic  meas_valid,
    input  logic  meas_outside,
    input  logic  clr,
    output logic  flag
);

    typedef struct packed {
        cnt_t cnt;
        logic flag;
    } st_t;

    st_t st_d, st_q;
    cnt_t need;
    cnt_t bumped;

    always_comb begin
        st_d   = st_q;
        need   = persist_need(code);
        bumped = (st_q.cnt == cnt_t'(PERSIST_MAX)) ? st_q.cnt : st_q.cnt + cnt_t'(1);
        if (clr) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else if (meas_valid) begin
            if (meas_outside) begin
                st_d.cnt = bumped;
                if (bumped >= need) st_d.flag = 1'b1;
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= cnt_t'(PERSIST_MAX));

    a_r3_set_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(meas_valid && meas_outside && !clr));

    a_r3_set_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> st_q.cnt >= persist_need($past(code)));

    a_r4_inwindow_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && !meas_outside) |=> st_q.cnt == '0);

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_valid && !clr) |=> $stable(st_q.cnt));

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr) |=> st_q.flag);

    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!st_q.flag && st_q.cnt == '0));

endmodule

// File: rtl/dti_merge.sv
module dti_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_amb,
    input  logic flag_prx,
    input  logic sel_and,
    output logic irq_oe
);

    logic irq_d, irq_q;

    always_comb begin
        if (sel_and) irq_d = flag_amb & flag_prx;
        else         irq_d = flag_amb | flag_prx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_oe = irq_q;

    a_r8_and_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe && $past(sel_and)) |-> $past(flag_amb && flag_prx));

    a_r8_or_any: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_amb || flag_prx) && !$past(sel_and)) |-> irq_oe);

    a_r9_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!flag_amb && !flag_prx) |-> !irq_oe);

endmodule

// File: rtl/dual_thresh_irq.sv
module dual_thresh_irq
    import dti_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       amb_valid,
    input  logic       amb_outside,
    input  logic       prx_valid,
    input  logic       prx_outside,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_oe,
    output logic       irq_od
);

    cfg_t cfg_d, cfg_q;

    logic [NUM_CH-1:0] ch_valid;
    logic [NUM_CH-1:0] ch_outside;
    logic [NUM_CH-1:0] ch_clr;
    logic [NUM_CH-1:0] ch_flag;
    code_t             ch_code [NUM_CH];

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            cfg_d.prx_code = reg_wdata[BIT_PRX_CODE +: 2];
            cfg_d.amb_code = reg_wdata[BIT_AMB_CODE +: 2];
            cfg_d.sel_and  = reg_wdata[BIT_SEL];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        ch_valid[CH_AMB]   = amb_valid;
        ch_outside[CH_AMB] = amb_outside;
        ch_clr[CH_AMB]     = reg_wr & ~reg_wdata[BIT_AMB_FLAG];
        ch_code[CH_AMB]    = cfg_q.amb_code;
        ch_valid[CH_PRX]   = prx_valid;
        ch_outside[CH_PRX] = prx_outside;
        ch_clr[CH_PRX]     = reg_wr & ~reg_wdata[BIT_PRX_FLAG];
        ch_code[CH_PRX]    = cfg_q.prx_code;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dti_persist u_persist (
            .clk          (clk),
            .rst_n        (rst_n),
            .code         (ch_code[ch]),
            .meas_valid   (ch_valid[ch]),
            .meas_outside (ch_outside[ch]),
            .clr          (ch_clr[ch]),
            .flag         (ch_flag[ch])
        );
    end

    dti_merge u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_amb (ch_flag[CH_AMB]),
        .flag_prx (ch_flag[CH_PRX]),
        .sel_and  (cfg_q.sel_and),
        .irq_oe   (irq_oe)
    );

    always_comb begin
        reg_rdata                     = '0;
        reg_rdata[BIT_PRX_FLAG]       = ch_flag[CH_PRX];
        reg_rdata[BIT_PRX_CODE +: 2]  = cfg_q.prx_code;
        reg_rdata[BIT_AMB_FLAG]       = ch_flag[CH_AMB];
        reg_rdata[BIT_AMB_CODE +: 2]  = cfg_q.amb_code;
        reg_rdata[BIT_SEL]            = cfg_q.sel_and;
    end

    assign irq_od = 1'b0;

    a_r2_cfg_store: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[6:5] == $past(reg_wdata[6:5]) &&
                    reg_rdata[2:1] == $past(reg_wdata[2:1]) &&
                    reg_rdata[0]   == $past(reg_wdata[0])));

    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable({reg_rdata[6:5], reg_rdata[2:0]}) );

    a_r7_no_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !amb_valid && !reg_rdata[3]) |=> !reg_rdata[3]);

endmodule

// File: tb/dual_thresh_irq_bench.sv
module dual_thresh_irq_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       amb_valid = 1'b0, amb_outside = 1'b0;
    logic       prx_valid = 1'b0, prx_outside = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_oe, irq_od;

    int n_checks = 0;
    int n_fail   = 0;

    dual_thresh_irq u_dual_thresh_irq (
        .clk(clk), .rst_n(rst_n),
        .amb_valid(amb_valid), .amb_outside(amb_outside),
        .prx_valid(prx_valid), .prx_outside(prx_outside),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_oe(irq_oe), .irq_od(irq_od)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // scoreboard queues: expected {irq_oe, reg_rdata} and requirement tag
    logic [8:0] exp_q[$];
    string      tag_q[$];

    // reference state, index 0 ambient, 1 proximity
    int   m_cnt [2];
    logic m_flag[2];
    int   m_code[2];
    logic m_and;

    function automatic int need_of(int c);
        return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 16;
    endfunction

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {irq_oe,rdata} actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic wr, logic [7:0] wd,
                        logic av, logic ao, logic pv, logic po);
        logic       exp_oe;
        logic [7:0] exp_rd;
        logic       vld[2];
        logic       out[2];
        logic       clr[2];
        @(negedge clk);
        reg_wr = wr; reg_wdata = wd;
        amb_valid = av; amb_outside = ao;
        prx_valid = pv; prx_outside = po;
        exp_oe = m_and ? (m_flag[0] && m_flag[1]) : (m_flag[0] || m_flag[1]);
        vld[0] = av; out[0] = ao; clr[0] = wr && !wd[3];
        vld[1] = pv; out[1] = po; clr[1] = wr && !wd[7];
        for (int c = 0; c < 2; c++) begin
            if (clr[c]) begin
                m_cnt[c] = 0; m_flag[c] = 1'b0;
            end else if (vld[c]) begin
                if (out[c]) begin
                    if (m_cnt[c] < 16) m_cnt[c]++;
                    if (m_cnt[c] >= need_of(m_code[c])) m_flag[c] = 1'b1;
                end else begin
                    m_cnt[c] = 0;
                end
            end
        end
        if (wr) begin
            m_code[0] = int'(wd[2:1]);
            m_code[1] = int'(wd[6:5]);
            m_and     = wd[0];
        end
        exp_rd = {m_flag[1], 2'(m_code[1]), 1'b0, m_flag[0], 2'(m_code[0]), m_and};
        exp_q.push_back({exp_oe, exp_rd});
        tag_q.push_back(tag);
    endtask

    task automatic idle(string tag);
        step(tag, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // monitor: compares one expected item per clock, just after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                logic [8:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {irq_oe, reg_rdata}, e);
                n_checks++;
                if (irq_od !== 1'b0) begin
                    n_fail++;
                    $display("FAIL R9: irq_od actual=%b expected=0", irq_od);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_cnt[c] = 0; m_flag[c] = 1'b0; m_code[c] = 0;
        end
        m_and = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", {irq_oe, reg_rdata}, 9'h000);
        rst_n = 1'b1;

        // R7 and R2: writing ones to flags sets nothing; bit 4 reads 0
        step("R7", 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
        idle("R7");
        step("R2", 1'b1, 8'hBC, 1'b0, 1'b0, 1'b0, 1'b0);
        idle("R2");

        // R3: each ambient persistence code, merge OR
        for (int code = 0; code < 4; code++) begin
            step("R3", 1'b1, {1'b1, 2'b00, 1'b0, 1'b0, 2'(code), 1'b0}, 1'b0, 1'b0, 1'b0, 1'b0);
            for (int k = 0; k < need_of(code); k++)
                step("R3", 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
            idle("R9");
            idle("R3");
        end

        // R4: in-window strobe restarts the run, idle cycles do not
        step("R4", 1'b1, 8'h82, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) step("R4", 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
        step("R4", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            step("R4", 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
            idle("R4");
        end
        step("R4", 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
        idle("R4");

        // R5: flag sticky under in-window strobes
        for (int k = 0; k < 4; k++) step("R5", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);

        // R6: clear, and clear beats a same-cycle completing strobe
        step("R6", 1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0);
        idle("R6");
        step("R6", 1'b1, 8'h80, 1'b1, 1'b1, 1'b0, 1'b0);
        idle("R6");
        // write with flag bit 1 does not stop a completing strobe
        step("R7", 1'b1, 8'h88, 1'b1, 1'b1, 1'b0, 1'b0);
        idle("R7");

        // R8: AND merge, proximity code 10 (8 strobes)
        step("R8", 1'b1, 8'hC9, 1'b0, 1'b0, 1'b0, 1'b0);
        idle("R8");
        for (int k = 0; k < 8; k++) step("R8", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
        idle("R9");
        idle("R8");
        // switch merge to OR, then clear proximity only, then AND again
        step("R8", 1'b1, 8'hC8, 1'b0, 1'b0, 1'b0, 1'b0);
        idle("R9");
        step("R6", 1'b1, 8'h48, 1'b0, 1'b0, 1'b0, 1'b0);
        idle("R9");
        step("R8", 1'b1, 8'h49, 1'b0, 1'b0, 1'b0, 1'b0);
        idle("R8");
        // clear everything: interrupt releases one edge later
        step("R6", 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        idle("R9");
        idle("R9");

        @(negedge clk);
        reg_wr = 1'b0; amb_valid = 1'b0; prx_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule